// File: doc/BRIEF.md
# Decimal Digit Multiplier

This block multiplies two single decimal digits, each held in 8-4-2-1 coded form, and returns their product as two decimal digits: the tens digit in the upper nibble of the result and the units digit in the lower nibble. It is purely combinational, so the product follows the operands within the same cycle. It is meant to sit inside wider decimal datapaths, where many such digit products are later aligned and summed.

Every result bit is formed directly in the decimal domain. Each operand is decoded into a one-of-ten line. The hundred pairwise digit terms are then gathered into each output bit by OR masks that are fixed when the design is elaborated. There is no binary product and no binary-to-decimal conversion step. Two output bits need almost no logic and are built from a handful of operand bits. The units parity bit needs the two operand low bits, and the top tens bit needs four operand bits, because only 9 x 9 reaches 80.

Operand codes from ten to fifteen are outside the contract, and the result for them is unspecified.

Top module: `bcd_digit_mul`

## Requirements
- R1: For operands a and b in 0..9, p[7:4] equals the tens digit and p[3:0] equals the units digit of a times b, each in 8-4-2-1 code.
- R2: For valid operands, p[3:0] never exceeds 9 and p[7:4] never exceeds 8.
- R3: When either operand is zero, p is 8'h00.
- R4: When one operand is one, p equals {4'b0000, other operand}.
- R5: For valid operands, the units digit equals 5 exactly when one operand is 5 and the other operand is odd.
- R6: For valid operands, p[7] is set only when both operands are 9, and it is formed from a[3], a[0], b[3] and b[0] alone.
- R7: For valid operands, p[0] equals a[0] AND b[0].
- R8: 7 x 7 gives p = 8'h49, 8 x 5 gives p = 8'h40 and 9 x 9 gives p = 8'h81.
- R9: Swapping the operands leaves p unchanged.
- R10: The block holds no state, and p settles to the new product within the same cycle in which the operands change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 4 | First operand digit, 8-4-2-1 code, 0..9 |
| b | input | 4 | Second operand digit, 8-4-2-1 code, 0..9 |
| p | output | 8 | Product: tens digit in [7:4], units digit in [3:0] |

## Verification
The assertions assume that both operands are valid decimal codes and known. Each check first tests that a and b are no larger than 9 and contain no unknown bits, so codes ten to fifteen and the values before the first stimulus raise nothing. The directed tasks only ever drive values from 0 to 9. Each pair is held for a full cycle and sampled one nanosecond after it is applied, so every check sees settled logic.

// File: rtl/bcd_digit_mul_pkg.sv
package bcd_digit_mul_pkg;
  localparam int DIGIT_W = 4;
  localparam int RADIX   = 10;
  localparam int PAIRS   = RADIX * RADIX;

  typedef logic [DIGIT_W-1:0] digit_t;
  typedef logic [RADIX-1:0]   onehot_t;
  typedef logic [PAIRS-1:0]   pair_vec_t;

  // Elaboration-time selection mask: which (i,j) digit pairs set a given bit
  // of the tens or units digit. Index is i*RADIX + j.
  function automatic pair_vec_t pair_mask(input bit tens_sel, input int bit_pos);
    pair_vec_t m;
    m = '0;
    for (int i = 0; i < RADIX; i++) begin
      for (int j = 0; j < RADIX; j++) begin
        int prod;
        int dig;
        prod = i * j;
        dig  = tens_sel ? (prod / RADIX) : (prod % RADIX);
        m[i*RADIX + j] = ((dig >> bit_pos) & 1) != 0;
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/bcdmul_decode.sv
// Decodes one decimal digit into ten select lines, using codes 10..15 as
// don't-care so that 8 and 9 need only two bits each.
module bcdmul_decode
  import bcd_digit_mul_pkg::*;
(
  input  digit_t  dig,
  output onehot_t sel
);
  localparam int LOW_W = DIGIT_W - 1;
  localparam int LOW_N = 1 << LOW_W;

  for (genvar k = 0; k < RADIX; k++) begin : g_line
    if (k < LOW_N) begin : g_low
      assign sel[k] = ~dig[DIGIT_W-1] && (dig[LOW_W-1:0] == LOW_W'(k));
    end else begin : g_high
      assign sel[k] = dig[DIGIT_W-1] && (dig[0] == k[0]);
    end
  end
endmodule

// File: rtl/bcdmul_plane.sv
// Sum-of-terms plane: forms the pairwise digit terms and ORs the terms that
// set each output bit in the range FIRST_BIT..LAST_BIT of one result digit.
module bcdmul_plane
  import bcd_digit_mul_pkg::*;
#(
  parameter bit TENS_SEL  = 1'b0,
  parameter int FIRST_BIT = 0,
  parameter int LAST_BIT  = DIGIT_W - 1,
  localparam int OUT_W    = LAST_BIT - FIRST_BIT + 1
) (
  input  onehot_t          sel_a,
  input  onehot_t          sel_b,
  output logic [OUT_W-1:0] bits
);
  pair_vec_t term;

  for (genvar i = 0; i < RADIX; i++) begin : g_row
    for (genvar j = 0; j < RADIX; j++) begin : g_col
      assign term[i*RADIX + j] = sel_a[i] & sel_b[j];
    end
  end

  for (genvar k = 0; k < OUT_W; k++) begin : g_bit
    localparam pair_vec_t MASK = pair_mask(TENS_SEL, FIRST_BIT + k);
    assign bits[k] = |(term & MASK);
  end
endmodule

// File: rtl/bcdmul_edge_bits.sv
// The two result bits with very small support: units parity and tens bit 3.
module bcdmul_edge_bits
  import bcd_digit_mul_pkg::*;
(
  input  digit_t a,
  input  digit_t b,
  output logic   units_lsb,
  output logic   tens_msb
);
  localparam int MSB = DIGIT_W - 1;

  always_comb begin
    units_lsb = a[0] & b[0];
    tens_msb  = a[MSB] & a[0] & b[MSB] & b[0];
  end
endmodule

// File: rtl/bcd_digit_mul.sv
module bcd_digit_mul
  import bcd_digit_mul_pkg::*;
(
  input  logic [3:0] a,
  input  logic [3:0] b,
  output logic [7:0] p
);
  localparam int MSB = DIGIT_W - 1;

  onehot_t          sel_a;
  onehot_t          sel_b;
  logic [MSB-1:0]   units_mid;
  logic [MSB-1:0]   tens_low;
  logic             units_lsb;
  logic             tens_msb;

  bcdmul_decode u_dec_a (.dig(a), .sel(sel_a));
  bcdmul_decode u_dec_b (.dig(b), .sel(sel_b));

  bcdmul_plane #(.TENS_SEL(1'b0), .FIRST_BIT(1), .LAST_BIT(MSB)) u_units (
    .sel_a(sel_a), .sel_b(sel_b), .bits(units_mid)
  );

  bcdmul_plane #(.TENS_SEL(1'b1), .FIRST_BIT(0), .LAST_BIT(MSB-1)) u_tens (
    .sel_a(sel_a), .sel_b(sel_b), .bits(tens_low)
  );

  bcdmul_edge_bits u_edge (
    .a(a), .b(b), .units_lsb(units_lsb), .tens_msb(tens_msb)
  );

  assign p = {tens_msb, tens_low, units_mid, units_lsb};
endmodule

// File: rtl/bcd_digit_mul_chk.sv
module bcd_digit_mul_chk (
  input logic [3:0] a,
  input logic [3:0] b,
  input logic [7:0] p
);
  logic ok_in;

  always_comb begin
    ok_in = !$isunknown({a, b}) && (a <= 4'd9) && (b <= 4'd9);
    if (ok_in) begin
      p_zero_r3: assert (!((a == 4'd0) || (b == 4'd0)) || (p == 8'h00))
        else $error("R3 zero operand gave p=%h", p);
      p_digits_r2: assert ((p[3:0] <= 4'd9) && (p[7:4] <= 4'd8))
        else $error("R2 digit range p=%h", p);
      p_ident_r4: assert (!(a == 4'd1) || (p == {4'd0, b}))
        else $error("R4 identity a=1 b=%0d p=%h", b, p);
      p_ident_b_r4: assert (!(b == 4'd1) || (p == {4'd0, a}))
        else $error("R4 identity b=1 a=%0d p=%h", a, p);
      p_five_r5: assert ((p[3:0] == 4'd5) == (((a == 4'd5) && b[0]) || ((b == 4'd5) && a[0])))
        else $error("R5 five rule a=%0d b=%0d p=%h", a, b, p);
      p_top_r6: assert (!p[7] || ((a == 4'd9) && (b == 4'd9)))
        else $error("R6 top bit a=%0d b=%0d", a, b);
      p_odd_r7: assert (p[0] == (a[0] && b[0]))
        else $error("R7 parity a=%0d b=%0d p=%h", a, b, p);
    end
  end
endmodule

bind bcd_digit_mul bcd_digit_mul_chk u_chk (.a(a), .b(b), .p(p));

// File: tb/tb_bcd_digit_mul.sv
`timescale 1ns/1ps
module tb_bcd_digit_mul;
  logic       clk;
  logic [3:0] a;
  logic [3:0] b;
  logic [7:0] p;
  int n_cmp;
  int n_bad;
  bit done;

  bcd_digit_mul dut (.a(a), .b(b), .p(p));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] ref_prod(input int x, input int y);
    int r;
    r = x * y;
    return {4'(r / 10), 4'(r % 10)};
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s a=%0d b=%0d actual=%h expected=%h", req, a, b, got, exp);
    end
  endtask

  task automatic apply(input int x, input int y);
    @(posedge clk);
    a = 4'(x);
    b = 4'(y);
    #1;
  endtask

  task automatic t_anchors_r8;
    apply(7, 7); check("R8", p, 8'h49);
    apply(8, 5); check("R8", p, 8'h40);
    apply(9, 9); check("R8", p, 8'h81);
  endtask

  task automatic t_zero_r3;
    for (int k = 0; k < 10; k++) begin
      apply(0, k); check("R3", p, 8'h00);
      apply(k, 0); check("R3", p, 8'h00);
    end
  endtask

  task automatic t_ident_r4;
    for (int k = 0; k < 10; k++) begin
      apply(1, k); check("R4", p, {4'd0, 4'(k)});
      apply(k, 1); check("R4", p, {4'd0, 4'(k)});
    end
  endtask

  task automatic t_sweep_r1;
    for (int x = 0; x < 10; x++) begin
      for (int y = 0; y < 10; y++) begin
        logic [7:0] e;
        e = ref_prod(x, y);
        apply(x, y);
        check("R1", p, e);
        check("R2", {3'd0, (p[3:0] <= 4'd9) && (p[7:4] <= 4'd8)}, 8'h01);
        check("R5", {7'd0, p[3:0] == 4'd5}, {7'd0, ((x == 5) && (y % 2 == 1)) || ((y == 5) && (x % 2 == 1))});
        check("R6", {7'd0, p[7]}, {7'd0, (x == 9) && (y == 9)});
        check("R7", {7'd0, p[0]}, {7'd0, (x % 2 == 1) && (y % 2 == 1)});
      end
    end
  endtask

  task automatic t_commute_r9;
    for (int x = 0; x < 10; x++) begin
      for (int y = x + 1; y < 10; y++) begin
        logic [7:0] fwd;
        apply(x, y);
        fwd = p;
        apply(y, x);
        check("R9", p, fwd);
      end
    end
  endtask

  task automatic t_settle_r10;
    apply(6, 7); check("R10", p, 8'h42);
    a = 4'd3;
    #0.5;
    check("R10", p, 8'h21);
    b = 4'd2;
    #0.5;
    check("R10", p, 8'h06);
  endtask

  initial begin
    n_cmp = 0;
    n_bad = 0;
    done  = 1'b0;
    a = 4'd0;
    b = 4'd0;
    repeat (2) @(posedge clk);
    #1;
    check("R3", p, 8'h00);
    t_anchors_r8();
    t_zero_r3();
    t_ident_r4();
    t_sweep_r1();
    t_commute_r9();
    t_settle_r10();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule